// File: doc/BRIEF.md
# Serial Video Pixel Deserializer

The block takes one, two or three serial lanes and rebuilds 30-bit pixel words. Each word holds 24 colour bits, three timing bits (horizontal sync, vertical sync, data enable), two auxiliary bits and one parity bit. The lanes are sampled on cycles where a bit-rate enable is high. When a word is complete, the block presents it on parallel outputs with a one-cycle strobe. It also flags a parity error if the parity bit does not match the colour and timing bits.

There are two ways to find where a pixel starts. In marker framing, a pixel-start marker is sampled along with the data, and its rising edge marks the first slot of a pixel. In word framing, the block searches the bit stream for a fixed synchronization word. It locks once that word appears twice at the same bit offset, and it re-searches after the word keeps turning up at the wrong offset.

A clock-present input stands in for the missing-clock detector. While it is low, the block sits in standby with everything cleared. Lane count and framing mode are static settings; change them only under reset or standby.

Top module: `vid_rx_deser`

## Requirements
- R1: After reset all outputs are zero: no strobe, not locked, no parity error, and all pixel fields zero.
- R2: Word bit layout and lane mapping:
  - Word bits: red bits 7:0, green bits 15:8, blue bits 23:16, hsync bit 24, vsync bit 25, data enable bit 26, aux bits 28:27, parity bit 29.
  - Lane count: `lane_sel` 00 selects one lane, 01 selects two, 10 or 11 select three. A pixel then takes 30/N slots.
  - Mapping: in slot s, lane l carries word bit s*N+l.
- R3: The parity is even over bits 26:0, so bit 29 must equal their XOR. `par_err` is registered with each decoded pixel and is 1 exactly when bit 29 differs from that XOR.
- R4: In marker framing (`word_frame`=0), a slot whose marker is 1 while the previous slot's marker was 0 is slot 0 of a pixel, and the first such rise sets `locked`. The pixel is output one clock after the enable edge of its last slot, with a one-cycle `pix_valid`.
- R5: In marker framing, a marker rise before the current pixel is complete discards the partial pixel and starts a new one.
- R6: In word framing (`word_frame`=1), one sync word does not lock. A second sync word ending a whole number of pixels later sets `locked`. That confirming sync word is not output; the pixels after it are.
- R7: While locked in word framing, a sync word at the expected offset is output as an ordinary pixel.
- R8: While locked in word framing, four consecutive sync words at a wrong offset clear `locked`. The fourth starts a new candidate offset, so one more sync word at that offset locks again.
- R9: While not locked, `pix_valid` stays 0 and all pixel fields and `par_err` read zero.
- R10: While `clk_ok` is 0, the block unlocks one clock later, clears its outputs and ignores lane data. Once `clk_ok` returns, no pixel is output until framing is found again.
- R11: `pix_valid` is never high on two consecutive clocks. Pixel fields and `par_err` hold their values between strobes while locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_ok | input | 1 | Link clock detected; low forces standby |
| bit_en | input | 1 | Slot enable: lanes and marker are sampled on this cycle |
| lane_sel | input | 2 | Lane count code (00 one, 01 two, else three) |
| word_frame | input | 1 | 0 selects marker framing, 1 selects sync-word framing |
| pix_mark | input | 1 | Pixel-start marker, sampled with `bit_en` |
| lane_in | input | 3 | Serial lane bits, lane 0 at bit 0 |
| pix_valid | output | 1 | One-cycle strobe for a decoded pixel |
| red | output | 8 | Red component |
| grn | output | 8 | Green component |
| blu | output | 8 | Blue component |
| hsync | output | 1 | Horizontal sync bit |
| vsync | output | 1 | Vertical sync bit |
| den | output | 1 | Data enable bit |
| aux | output | 2 | Auxiliary bits |
| par_err | output | 1 | Parity mismatch for the current pixel |
| locked | output | 1 | Pixel framing established |

## Verification
The bench targets these corner cases:
- **Lane interleave.** The bench drives every lane count with random pixels. A design that reversed lane order or packed the lanes as contiguous blocks would output scrambled colours.
- **Aborted pixel.** A marker rise arrives four slots into a pixel. A design that kept the partial bits would emit one extra, garbled pixel.
- **Lock threshold.** Alignment is probed at exactly one sync word versus two. A design that locked on the first sync word would output pixels too early.
- **Drop threshold.** The bench inserts a single stray slot and then sends sync words at the shifted offset, checking the lock at the third miss versus the fourth. A design that did not reuse the fourth miss as a new candidate would need an extra sync word to relock.
- **Stale parity error.** The bench checks that a parity error latched before standby does not survive into standby, and that no pixel escapes while the link clock is absent.

// File: rtl/vid_rx_pkg.sv
package vid_rx_pkg;

  localparam int PIX_W     = 30;
  localparam int COLOR_W   = 8;
  localparam int MAX_LANES = 3;
  localparam int BODY_W    = 3 * COLOR_W + 3;

  typedef struct packed {
    logic               par;
    logic [1:0]         aux;
    logic               de;
    logic               vs;
    logic               hs;
    logic [COLOR_W-1:0] b;
    logic [COLOR_W-1:0] g;
    logic [COLOR_W-1:0] r;
  } pix_word_t;

  // lanes in use for a lane_sel code
  function automatic int unsigned lane_count(logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 2;
      default: return 3;
    endcase
  endfunction

  // serial slots that make up one pixel
  function automatic int unsigned slot_count(logic [1:0] sel);
    return PIX_W / lane_count(sel);
  endfunction

  // even parity over colour and timing bits
  function automatic logic body_parity(pix_word_t w);
    return ^{w.de, w.vs, w.hs, w.b, w.g, w.r};
  endfunction

  function automatic logic parity_bad(pix_word_t w);
    return w.par != body_parity(w);
  endfunction

endpackage

// File: rtl/vid_rx_shift.sv
module vid_rx_shift
  import vid_rx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 bit_en,
  input  logic [1:0]           lane_sel,
  input  logic [MAX_LANES-1:0] lane_in,
  output logic [PIX_W-1:0]     win_nx
);

  logic [PIX_W-1:0] win_q;
  logic [PIX_W-1:0] shifted;
  int unsigned      nl;

  // oldest slot drifts to bit 0; the newest slot enters at the top
  always_comb begin
    nl      = lane_count(lane_sel);
    shifted = win_q;
    for (int n = 1; n <= MAX_LANES; n++) begin
      if (nl == n) begin
        shifted = win_q >> n;
        for (int l = 0; l < n; l++) shifted[PIX_W-n+l] = lane_in[l];
      end
    end
  end

  assign win_nx = bit_en ? shifted : win_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) win_q <= '0;
    else               win_q <= win_nx;
  end

endmodule

// File: rtl/vid_rx_align.sv
module vid_rx_align
  import vid_rx_pkg::*;
#(
  parameter logic [PIX_W-1:0] SYNC_WORD   = 30'h0F0AC35B,
  parameter int               LOCK_HITS   = 2,
  parameter int               DROP_MISSES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_ok,
  input  logic             bit_en,
  input  logic             word_frame,
  input  logic             pix_mark,
  input  logic [1:0]       lane_sel,
  input  logic [PIX_W-1:0] win_nx,
  output logic             lock_q,
  output logic             lock_nx,
  output logic             word_done,
  output logic             sync_hit,
  output logic             mark_rise
);

  localparam int CNT_W  = $clog2(PIX_W);
  localparam int HIT_W  = $clog2(LOCK_HITS + 1);
  localparam int MISS_W = $clog2(DROP_MISSES + 1);
  localparam logic [HIT_W-1:0]  HIT_LAST  = HIT_W'(LOCK_HITS - 1);
  localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(DROP_MISSES - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d, cur, last;
  logic [HIT_W-1:0]  hit_q, hit_d;
  logic [MISS_W-1:0] miss_q, miss_d;
  logic              mark_q, mark_d;
  logic              at_end;

  assign last      = CNT_W'(slot_count(lane_sel) - 1);
  assign mark_rise = bit_en && clk_ok && !word_frame && pix_mark && !mark_q;
  assign sync_hit  = bit_en && clk_ok && word_frame && (win_nx == SYNC_WORD);
  assign cur       = mark_rise ? '0 : cnt_q;
  assign at_end    = (cur == last);
  assign word_done = bit_en && clk_ok && lock_q && at_end;

  always_comb begin
    cnt_d   = cnt_q;
    hit_d   = hit_q;
    miss_d  = miss_q;
    mark_d  = mark_q;
    lock_nx = lock_q;
    if (!clk_ok) begin
      cnt_d   = '0;
      hit_d   = '0;
      miss_d  = '0;
      mark_d  = 1'b0;
      lock_nx = 1'b0;
    end else if (bit_en) begin
      mark_d = pix_mark;
      cnt_d  = at_end ? '0 : cur + 1'b1;
      if (!word_frame) begin
        if (mark_rise) lock_nx = 1'b1;
      end else if (sync_hit) begin
        if (!lock_q) begin
          if (at_end && hit_q != '0) begin
            if (hit_q == HIT_LAST) begin
              lock_nx = 1'b1;
              hit_d   = '0;
              miss_d  = '0;
            end else begin
              hit_d = hit_q + 1'b1;
            end
          end else begin
            hit_d = HIT_W'(1);
            cnt_d = '0;
          end
        end else if (at_end) begin
          miss_d = '0;
        end else if (miss_q == MISS_LAST) begin
          lock_nx = 1'b0;
          miss_d  = '0;
          hit_d   = HIT_W'(1);
          cnt_d   = '0;
        end else begin
          miss_d = miss_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hit_q  <= '0;
      miss_q <= '0;
      mark_q <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      hit_q  <= hit_d;
      miss_q <= miss_d;
      mark_q <= mark_d;
      lock_q <= lock_nx;
    end
  end

endmodule

// File: rtl/vid_rx_decode.sv
module vid_rx_decode
  import vid_rx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               keep,
  input  logic               load,
  input  logic [PIX_W-1:0]   win_nx,
  output logic               pix_valid,
  output logic [COLOR_W-1:0] red,
  output logic [COLOR_W-1:0] grn,
  output logic [COLOR_W-1:0] blu,
  output logic               hsync,
  output logic               vsync,
  output logic               den,
  output logic [1:0]         aux,
  output logic               par_err
);

  pix_word_t w;
  assign w = pix_word_t'(win_nx);

  always_ff @(posedge clk) begin
    if (!rst_n || !keep) begin
      pix_valid <= 1'b0;
      red       <= '0;
      grn       <= '0;
      blu       <= '0;
      hsync     <= 1'b0;
      vsync     <= 1'b0;
      den       <= 1'b0;
      aux       <= '0;
      par_err   <= 1'b0;
    end else begin
      pix_valid <= load;
      if (load) begin
        red     <= w.r;
        grn     <= w.g;
        blu     <= w.b;
        hsync   <= w.hs;
        vsync   <= w.vs;
        den     <= w.de;
        aux     <= w.aux;
        par_err <= parity_bad(w);
      end
    end
  end

endmodule

// File: rtl/vid_rx_deser.sv
module vid_rx_deser
  import vid_rx_pkg::*;
#(
  parameter logic [PIX_W-1:0] SYNC_WORD   = 30'h0F0AC35B,
  parameter int               LOCK_HITS   = 2,
  parameter int               DROP_MISSES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clk_ok,
  input  logic                 bit_en,
  input  logic [1:0]           lane_sel,
  input  logic                 word_frame,
  input  logic                 pix_mark,
  input  logic [MAX_LANES-1:0] lane_in,
  output logic                 pix_valid,
  output logic [COLOR_W-1:0]   red,
  output logic [COLOR_W-1:0]   grn,
  output logic [COLOR_W-1:0]   blu,
  output logic                 hsync,
  output logic                 vsync,
  output logic                 den,
  output logic [1:0]           aux,
  output logic                 par_err,
  output logic                 locked
);

  logic [PIX_W-1:0] win_nx;
  logic             lock_nx;
  logic             word_done;
  logic             sync_hit;
  logic             mark_rise;

  vid_rx_shift u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (!clk_ok),
    .bit_en   (bit_en),
    .lane_sel (lane_sel),
    .lane_in  (lane_in),
    .win_nx   (win_nx)
  );

  vid_rx_align #(
    .SYNC_WORD   (SYNC_WORD),
    .LOCK_HITS   (LOCK_HITS),
    .DROP_MISSES (DROP_MISSES)
  ) u_align (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_ok     (clk_ok),
    .bit_en     (bit_en),
    .word_frame (word_frame),
    .pix_mark   (pix_mark),
    .lane_sel   (lane_sel),
    .win_nx     (win_nx),
    .lock_q     (locked),
    .lock_nx    (lock_nx),
    .word_done  (word_done),
    .sync_hit   (sync_hit),
    .mark_rise  (mark_rise)
  );

  vid_rx_decode u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .keep      (lock_nx),
    .load      (word_done),
    .win_nx    (win_nx),
    .pix_valid (pix_valid),
    .red       (red),
    .grn       (grn),
    .blu       (blu),
    .hsync     (hsync),
    .vsync     (vsync),
    .den       (den),
    .aux       (aux),
    .par_err   (par_err)
  );

endmodule

// File: rtl/vid_rx_deser_chk.sv
module vid_rx_deser_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clk_ok,
  input logic       pix_valid,
  input logic [7:0] red,
  input logic [7:0] grn,
  input logic [7:0] blu,
  input logic       hsync,
  input logic       vsync,
  input logic       den,
  input logic [1:0] aux,
  input logic       par_err,
  input logic       locked,
  input logic       word_done,
  input logic       sync_hit,
  input logic       mark_rise
);

  // R11: strobe lasts one clock
  a_r11_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> !pix_valid);

  // R11: fields only move with a strobe while lock holds
  a_r11_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked) && !pix_valid) |->
      ($stable({red, grn, blu, hsync, vsync, den, aux, par_err})));

  // R9: unlocked outputs are quiet
  a_r9_quiet_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (!pix_valid && !par_err &&
                 {red, grn, blu, hsync, vsync, den, aux} == 29'd0));

  // R10: missing clock unlocks on the next edge
  a_r10_standby_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_ok |=> !locked);

  // R4: a completed word becomes a strobe one clock later
  a_r4_done_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> pix_valid);

  // R4 R6: lock rises only after a marker rise or sync match
  a_r6_lock_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(sync_hit || mark_rise));

endmodule

bind vid_rx_deser vid_rx_deser_chk u_chk (.*);

// File: tb/vid_rx_deser_tb_top.sv
module vid_rx_deser_tb_top;

  localparam int          CLK_PERIOD = 10;
  localparam logic [29:0] SYNC       = 30'h0F0AC35B;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_ok = 1'b1;
  logic       bit_en = 1'b0;
  logic [1:0] lane_sel = 2'b00;
  logic       word_frame = 1'b0;
  logic       pix_mark = 1'b0;
  logic [2:0] lane_in = 3'b000;
  logic       pix_valid, hsync, vsync, den, par_err, locked;
  logic [7:0] red, grn, blu;
  logic [1:0] aux;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_rx_deser #(.SYNC_WORD(SYNC)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_ok(clk_ok), .bit_en(bit_en),
    .lane_sel(lane_sel), .word_frame(word_frame), .pix_mark(pix_mark),
    .lane_in(lane_in), .pix_valid(pix_valid), .red(red), .grn(grn),
    .blu(blu), .hsync(hsync), .vsync(vsync), .den(den), .aux(aux),
    .par_err(par_err), .locked(locked)
  );

  int          n_tests = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;
  bit          content_on = 1'b1;
  logic [29:0] exp_q[$];
  logic [29:0] last_word = '0;
  logic [29:0] mon_w;

  function automatic logic calc_par(logic [29:0] w);
    logic p = 1'b0;
    for (int i = 0; i < 27; i++) p = p ^ w[i];
    return p;
  endfunction

  // expected output view: {par_err, aux, den, vsync, hsync, blu, grn, red}
  function automatic logic [29:0] expect_view(logic [29:0] w);
    return {w[29] ^ calc_par(w), w[28:0]};
  endfunction

  function automatic logic [29:0] rand_pix(bit bad);
    logic [29:0] w;
    w[26:0]  = 27'($urandom);
    w[28:27] = 2'($urandom);
    w[29]    = 1'b0;
    w[29]    = calc_par(w) ^ bad;
    return w;
  endfunction

  function automatic logic [29:0] out_view();
    return {par_err, aux, den, vsync, hsync, blu, grn, red};
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && pix_valid && content_on) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9", "unexpected strobe", {2'b0, out_view()}, 32'h0);
      end else begin
        mon_w = exp_q.pop_front();
        last_word = mon_w;
        check(out_view() == expect_view(mon_w), "R2 R3", "pixel fields",
              {2'b0, out_view()}, {2'b0, expect_view(mon_w)});
      end
    end
  end

  task automatic send_slot(logic [2:0] bits, logic mark);
    @(negedge clk);
    lane_in  = bits;
    pix_mark = mark;
    bit_en   = 1'b1;
    @(negedge clk);
    bit_en   = 1'b0;
  endtask

  task automatic send_word(logic [29:0] w, bit expect_it);
    int n = (lane_sel == 2'b00) ? 1 : (lane_sel == 2'b01) ? 2 : 3;
    int k = 30 / n;
    logic [2:0] bits;
    if (expect_it) exp_q.push_back(w);
    for (int s = 0; s < k; s++) begin
      bits = 3'b000;
      for (int l = 0; l < n; l++) bits[l] = w[s*n+l];
      send_slot(bits, !word_frame && (s < (k + 1) / 2));
    end
  endtask

  task automatic drained(string req);
    @(negedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, req, "pixels missing", exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic do_reset(logic [1:0] sel, logic wf);
    @(negedge clk);
    rst_n = 1'b0;
    lane_sel = sel;
    word_frame = wf;
    clk_ok = 1'b1;
    pix_mark = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic check_quiet(string req);
    check({pix_valid, locked, out_view()} == 32'h0, req, "outputs not quiet",
          {pix_valid, locked, out_view()}, 32'h0);
  endtask

  initial begin
    logic [29:0] w;
    void'($urandom(32'd4242));

    // R1 reset state, marker framing on one lane
    do_reset(2'b00, 1'b0);
    @(negedge clk);
    check_quiet("R1");

    // R9 data without a marker rise is ignored
    repeat (3) send_slot(3'b001, 1'b0);
    @(negedge clk);
    check_quiet("R9");

    // R4 R2 R3 one lane
    send_word(rand_pix(0), 1);
    send_word(rand_pix(0), 1);
    send_word(rand_pix(1), 1);
    drained("R4");
    check(locked == 1'b1, "R4", "lock after marker", locked, 1);

    // R11 hold between strobes
    repeat (8) @(negedge clk);
    check(out_view() == expect_view(last_word) && !pix_valid, "R11", "fields hold",
          {2'b0, out_view()}, {2'b0, expect_view(last_word)});

    // R2 two lanes, random parity faults
    do_reset(2'b01, 1'b0);
    for (int i = 0; i < 12; i++) send_word(rand_pix(($urandom % 4) == 0), 1);
    drained("R2");

    // R5 three lanes with an aborted pixel
    do_reset(2'b10, 1'b0);
    for (int i = 0; i < 4; i++) send_word(rand_pix(($urandom % 3) == 0), 1);
    w = rand_pix(0);
    for (int s = 0; s < 4; s++) send_slot(w[s*3 +: 3], s < 2);
    for (int i = 0; i < 3; i++) send_word(rand_pix(0), 1);
    drained("R5");

    // R6 word framing, three lanes
    do_reset(2'b10, 1'b1);
    send_word(rand_pix(0), 0);
    send_word(rand_pix(0), 0);
    send_word(SYNC, 0);
    send_word(rand_pix(0), 0);
    send_word(rand_pix(0), 0);
    @(negedge clk);
    check(locked == 1'b0, "R6", "locked on one sync", locked, 0);
    send_word(SYNC, 0);
    @(negedge clk);
    check(locked == 1'b1, "R6", "no lock on second sync", locked, 1);
    send_word(rand_pix(0), 1);
    send_word(rand_pix(1), 1);
    send_word(SYNC, 1);   // R7 sync passes as a pixel
    send_word(rand_pix(0), 1);
    drained("R7");

    // R8 shift the stream by one slot, then sync at the new offset
    content_on = 1'b0;
    send_slot(3'b101, 1'b0);
    for (int i = 0; i < 4; i++) begin
      send_word(SYNC, 0);
      @(negedge clk);
      if (i < 3) check(locked == 1'b1, "R8", "dropped too early", locked, 1);
      else       check(locked == 1'b0, "R8", "not dropped at fourth miss", locked, 0);
      send_word(rand_pix(0), 0);
    end
    @(negedge clk);
    check_quiet("R9");
    send_word(SYNC, 0);
    @(negedge clk);
    check(locked == 1'b1, "R8", "no relock at new offset", locked, 1);
    repeat (2) @(negedge clk);
    content_on = 1'b1;
    send_word(rand_pix(0), 1);
    send_word(rand_pix(1), 1);
    drained("R8");
    check(par_err == 1'b1, "R3", "parity flag", par_err, 1);

    // R10 standby clears state and ignores data
    @(negedge clk);
    clk_ok = 1'b0;
    repeat (2) @(negedge clk);
    check_quiet("R10");
    send_word(rand_pix(0), 0);
    send_word(SYNC, 0);
    check_quiet("R10");
    clk_ok = 1'b1;
    send_word(rand_pix(0), 0);
    send_word(rand_pix(0), 0);
    @(negedge clk);
    check(locked == 1'b0, "R10", "locked without resync", locked, 0);
    send_word(SYNC, 0);
    send_word(rand_pix(0), 0);
    send_word(SYNC, 0);
    for (int i = 0; i < 3; i++) send_word(rand_pix(i == 1), 1);
    drained("R10");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule